// File: doc/BRIEF.md
# Scheduled Crossbar Switch for a Neural Core Mesh

This block sits at each node of a mesh of neural cores and moves 8-bit neuron outputs between the four neighbouring links and the attached core. Feed-forward traffic between layers is known before the network runs, so the switch does no arbitration. A small table holds, for every slot of a repeating schedule, the input that each output copies. A counter walks the schedule one slot per clock while the schedule is enabled. One wire can therefore carry different neuron values in different slots.

Software or a loader fills the table through a write port while the schedule is stopped. It then raises the enable, and the switch replays the same pattern until the enable falls. An output can copy any input, including its own port's input. This lets the local core take its own results back as the next layer's inputs. Several outputs may copy the same input in one slot, so a value can be sent to more than one place at once.

Top module: `sched_xbar_switch`

## Requirements
- R1: After synchronous reset every `out_valid` bit is 0, all `out_data` is zero, and every table entry holds an idle code. Running the schedule before any write therefore produces no valid output.
- R2: While `sched_en` is high, output port o takes the data and valid of the input named by table entry (current slot, o), one clock after that input was presented. Data passes through even when the selected valid is low.
- R3: The select code value is 0 for north, 1 for east, 2 for south, 3 for west and 4 for local. Codes 5, 6 and 7 are idle: that output's valid is low and its data is zero in the following cycle.
- R4: The slot advances by one on every enabled clock. After slot `NUM_SLOTS-1` it wraps to slot 0.
- R5: When `sched_en` is low, all outputs show valid low and zero data one clock later, and the slot returns to 0. The first enabled cycle after that always uses slot 0.
- R6: A table write with `cfg_we` high while `sched_en` is low stores `cfg_sel` in entry (`cfg_slot`, `cfg_port`). The write is ignored when `sched_en` is high, and also when `cfg_port` is 5 or more.
- R7: One input may feed any number of outputs in the same slot. This includes the local input feeding the local output.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Switch clock, one slot per cycle |
| rst | input | 1 | Synchronous active-high reset |
| sched_en | input | 1 | Runs the schedule; low stops it and returns the slot to 0 |
| in_data | input | NUM_PORTS*DATA_W | Input link data, port p in bits [p*DATA_W +: DATA_W] |
| in_valid | input | NUM_PORTS | Input link valid, one bit per port |
| out_data | output | NUM_PORTS*DATA_W | Registered output link data, same packing as in_data |
| out_valid | output | NUM_PORTS | Registered output link valid |
| cfg_we | input | 1 | Table write strobe |
| cfg_slot | input | SLOT_W | Slot index of the entry to write |
| cfg_port | input | 3 | Output port of the entry to write |
| cfg_sel | input | 3 | Select code to store |

## Verification
The bench loads tables of random select codes, including idle codes, and drives random data and valid on all five inputs every cycle. This separates a wrong source choice from a wrong slot and shows each link's value one cycle late. Directed tables put the same source on every output, which exposes multicast and local loopback faults. Slot-distinct patterns run past the wrap and across a stop and restart, which shows whether the counter skips, sticks or fails to return to slot 0. Writes issued while the schedule runs, and writes that name a nonexistent port, are followed by runs that show the earlier table is unchanged.

// File: rtl/sxs_pkg.sv
package sxs_pkg;

    // Width of one select code in the schedule table
    localparam int SEL_W = 3;

    // Source select codes; any code at or above the port count is idle
    typedef enum logic [SEL_W-1:0] {
        SRC_NORTH = 3'd0,
        SRC_EAST  = 3'd1,
        SRC_SOUTH = 3'd2,
        SRC_WEST  = 3'd3,
        SRC_LOCAL = 3'd4,
        SRC_IDLE  = 3'd7
    } src_sel_e;

    // True when a code names a real input for a switch with n_ports ports
    function automatic logic sel_routes(input logic [SEL_W-1:0] code, input int n_ports);
        return int'(code) < n_ports;
    endfunction

endpackage

// File: rtl/sxs_slot_counter.sv
module sxs_slot_counter #(
    parameter int NUM_SLOTS = 8,
    localparam int SLOT_W = (NUM_SLOTS > 1) ? $clog2(NUM_SLOTS) : 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              run,
    output logic [SLOT_W-1:0] slot
);

    localparam logic [SLOT_W-1:0] LAST_SLOT = SLOT_W'(NUM_SLOTS - 1);

    always_ff @(posedge clk) begin
        if (rst || !run) begin
            slot <= '0;
        end else if (slot == LAST_SLOT) begin
            slot <= '0;
        end else begin
            slot <= slot + 1'b1;
        end
    end

endmodule

// File: rtl/sxs_sched_mem.sv
module sxs_sched_mem
    import sxs_pkg::*;
#(
    parameter int NUM_SLOTS = 8,
    parameter int NUM_PORTS = 5,
    localparam int SLOT_W = (NUM_SLOTS > 1) ? $clog2(NUM_SLOTS) : 1
) (
    input  logic                                clk,
    input  logic                                rst,
    input  logic                                wr_en,
    input  logic [SLOT_W-1:0]                   wr_slot,
    input  logic [SEL_W-1:0]                    wr_port,
    input  logic [SEL_W-1:0]                    wr_sel,
    input  logic [SLOT_W-1:0]                   rd_slot,
    output logic [NUM_PORTS*SEL_W-1:0]          rd_sel,
    output logic [NUM_SLOTS*NUM_PORTS*SEL_W-1:0] tbl_flat
);

    logic [SEL_W-1:0] entry_q [NUM_SLOTS][NUM_PORTS];

    // One register per (slot, port) entry, reset to idle
    for (genvar s = 0; s < NUM_SLOTS; s++) begin : g_slot
        for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
            localparam logic [SLOT_W-1:0] S_IDX = SLOT_W'(s);
            localparam logic [SEL_W-1:0]  P_IDX = SEL_W'(p);
            always_ff @(posedge clk) begin
                if (rst) begin
                    entry_q[s][p] <= SRC_IDLE;
                end else if (wr_en && wr_slot == S_IDX && wr_port == P_IDX) begin
                    entry_q[s][p] <= wr_sel;
                end
            end
            assign tbl_flat[(s*NUM_PORTS+p)*SEL_W +: SEL_W] = entry_q[s][p];
        end
    end

    // Read the whole row of the current slot
    always_comb begin
        rd_sel = '0;
        for (int s = 0; s < NUM_SLOTS; s++) begin
            if (rd_slot == SLOT_W'(s)) begin
                for (int p = 0; p < NUM_PORTS; p++) begin
                    rd_sel[p*SEL_W +: SEL_W] = entry_q[s][p];
                end
            end
        end
    end

endmodule

// File: rtl/sxs_out_port.sv
module sxs_out_port
    import sxs_pkg::*;
#(
    parameter int NUM_PORTS = 5,
    parameter int DATA_W    = 8
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic                        run,
    input  logic [SEL_W-1:0]            sel,
    input  logic [NUM_PORTS*DATA_W-1:0] in_data,
    input  logic [NUM_PORTS-1:0]        in_valid,
    output logic [DATA_W-1:0]           data_q,
    output logic                        valid_q
);

    logic [DATA_W-1:0] pick_data;
    logic              pick_valid;

    // Source multiplexer; idle codes leave the pick at zero
    always_comb begin
        pick_data  = '0;
        pick_valid = 1'b0;
        if (sel_routes(sel, NUM_PORTS)) begin
            for (int i = 0; i < NUM_PORTS; i++) begin
                if (sel == SEL_W'(i)) begin
                    pick_data  = in_data[i*DATA_W +: DATA_W];
                    pick_valid = in_valid[i];
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst || !run) begin
            data_q  <= '0;
            valid_q <= 1'b0;
        end else begin
            data_q  <= pick_data;
            valid_q <= pick_valid;
        end
    end

endmodule

// File: rtl/sched_xbar_switch.sv
module sched_xbar_switch
    import sxs_pkg::*;
#(
    parameter int NUM_PORTS = 5,
    parameter int DATA_W    = 8,
    parameter int NUM_SLOTS = 8,
    localparam int SLOT_W = (NUM_SLOTS > 1) ? $clog2(NUM_SLOTS) : 1
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic                        sched_en,
    input  logic [NUM_PORTS*DATA_W-1:0] in_data,
    input  logic [NUM_PORTS-1:0]        in_valid,
    output logic [NUM_PORTS*DATA_W-1:0] out_data,
    output logic [NUM_PORTS-1:0]        out_valid,
    input  logic                        cfg_we,
    input  logic [SLOT_W-1:0]           cfg_slot,
    input  logic [SEL_W-1:0]            cfg_port,
    input  logic [SEL_W-1:0]            cfg_sel
);

    localparam logic [SEL_W-1:0] PORT_LIMIT = SEL_W'(NUM_PORTS);
    localparam logic [SLOT_W:0]  SLOT_LIMIT = (SLOT_W+1)'(NUM_SLOTS);

    logic [SLOT_W-1:0]                    slot_q;
    logic [NUM_PORTS*SEL_W-1:0]           sel_cur;
    logic [NUM_SLOTS*NUM_PORTS*SEL_W-1:0] tbl_flat;
    logic                                 tbl_wr;

    // Table writes only while stopped, and only to real ports and slots
    assign tbl_wr = cfg_we && !sched_en && (cfg_port < PORT_LIMIT)
                    && ({1'b0, cfg_slot} < SLOT_LIMIT);

    sxs_slot_counter #(.NUM_SLOTS(NUM_SLOTS)) slot_i (
        .clk  (clk),
        .rst  (rst),
        .run  (sched_en),
        .slot (slot_q)
    );

    sxs_sched_mem #(.NUM_SLOTS(NUM_SLOTS), .NUM_PORTS(NUM_PORTS)) mem_i (
        .clk      (clk),
        .rst      (rst),
        .wr_en    (tbl_wr),
        .wr_slot  (cfg_slot),
        .wr_port  (cfg_port),
        .wr_sel   (cfg_sel),
        .rd_slot  (slot_q),
        .rd_sel   (sel_cur),
        .tbl_flat (tbl_flat)
    );

    for (genvar o = 0; o < NUM_PORTS; o++) begin : g_out
        sxs_out_port #(.NUM_PORTS(NUM_PORTS), .DATA_W(DATA_W)) port_i (
            .clk      (clk),
            .rst      (rst),
            .run      (sched_en),
            .sel      (sel_cur[o*SEL_W +: SEL_W]),
            .in_data  (in_data),
            .in_valid (in_valid),
            .data_q   (out_data[o*DATA_W +: DATA_W]),
            .valid_q  (out_valid[o])
        );
    end

endmodule

// File: rtl/sxs_checker.sv
module sxs_checker
    import sxs_pkg::*;
#(
    parameter int NUM_PORTS = 5,
    parameter int NUM_SLOTS = 8,
    localparam int SLOT_W = (NUM_SLOTS > 1) ? $clog2(NUM_SLOTS) : 1
) (
    input logic                                 clk,
    input logic                                 rst,
    input logic                                 sched_en,
    input logic [SLOT_W-1:0]                    slot,
    input logic [NUM_PORTS*SEL_W-1:0]           sel_cur,
    input logic [NUM_SLOTS*NUM_PORTS*SEL_W-1:0] tbl,
    input logic [NUM_PORTS-1:0]                 in_valid,
    input logic [NUM_PORTS-1:0]                 out_valid
);

    localparam logic [SLOT_W-1:0] LAST_SLOT  = SLOT_W'(NUM_SLOTS - 1);
    localparam logic [SEL_W-1:0]  PORT_LIMIT = SEL_W'(NUM_PORTS);

    logic [NUM_PORTS-1:0] want_v;

    always_comb begin
        want_v = '0;
        for (int o = 0; o < NUM_PORTS; o++) begin
            for (int i = 0; i < NUM_PORTS; i++) begin
                if (sel_cur[o*SEL_W +: SEL_W] == SEL_W'(i)) want_v[o] = in_valid[i];
            end
        end
    end

    // R4
    slot_wrap_chk: assert property (@(posedge clk) disable iff (rst)
        (sched_en && slot == LAST_SLOT) |=> (slot == '0));

    // R4
    slot_step_chk: assert property (@(posedge clk) disable iff (rst)
        (sched_en && slot != LAST_SLOT) |=> (slot == $past(slot) + 1'b1));

    // R5
    stop_slot_chk: assert property (@(posedge clk) disable iff (rst)
        !sched_en |=> (slot == '0));

    // R5
    stop_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        !sched_en |=> (out_valid == '0));

    // R6
    run_tbl_frozen_chk: assert property (@(posedge clk) disable iff (rst)
        sched_en |=> $stable(tbl));

    for (genvar o = 0; o < NUM_PORTS; o++) begin : g_chk
        // R2
        route_valid_chk: assert property (@(posedge clk) disable iff (rst)
            sched_en |=> (out_valid[o] == $past(want_v[o])));

        // R3
        idle_code_chk: assert property (@(posedge clk) disable iff (rst)
            (sched_en && sel_cur[o*SEL_W +: SEL_W] >= PORT_LIMIT) |=> !out_valid[o]);
    end

endmodule

bind sched_xbar_switch sxs_checker #(.NUM_PORTS(NUM_PORTS), .NUM_SLOTS(NUM_SLOTS)) chk_i (
    .clk       (clk),
    .rst       (rst),
    .sched_en  (sched_en),
    .slot      (slot_q),
    .sel_cur   (sel_cur),
    .tbl       (tbl_flat),
    .in_valid  (in_valid),
    .out_valid (out_valid)
);

// File: tb/sched_xbar_switch_tb_top.sv
`timescale 1ns/1ps
module sched_xbar_switch_tb_top;

    localparam int NP = 5;
    localparam int DW = 8;
    localparam int NS = 8;
    localparam int SW = 3;

    logic            clk = 1'b0;
    logic            rst;
    logic            sched_en;
    logic [NP*DW-1:0] in_data;
    logic [NP-1:0]   in_valid;
    logic [NP*DW-1:0] out_data;
    logic [NP-1:0]   out_valid;
    logic            cfg_we;
    logic [SW-1:0]   cfg_slot;
    logic [2:0]      cfg_port;
    logic [2:0]      cfg_sel;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    // Bench model
    int m_tbl [NS][NP];
    int m_slot;

    always #2.5 clk = ~clk;

    sched_xbar_switch #(.NUM_PORTS(NP), .DATA_W(DW), .NUM_SLOTS(NS)) dut_i (
        .clk(clk), .rst(rst), .sched_en(sched_en),
        .in_data(in_data), .in_valid(in_valid),
        .out_data(out_data), .out_valid(out_valid),
        .cfg_we(cfg_we), .cfg_slot(cfg_slot), .cfg_port(cfg_port), .cfg_sel(cfg_sel)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
        end
    endtask

    // Expected output valid/data for output o given current inputs and model
    function automatic int exp_valid(input int o);
        int s = m_tbl[m_slot][o];
        if (!sched_en || s >= NP) return 0;
        return int'(in_valid[s]);
    endfunction

    function automatic int exp_data(input int o);
        int s = m_tbl[m_slot][o];
        if (!sched_en || s >= NP) return 0;
        return int'(in_data[s*DW +: DW]);
    endfunction

    // One clock: drive at negedge, predict, compare at next negedge
    task automatic cycle(input bit en, input bit we, input int ws, input int wp, input int wsel,
                         input string req);
        int ev [NP];
        int ed [NP];
        sched_en = en;
        cfg_we   = we;
        cfg_slot = SW'(ws);
        cfg_port = 3'(wp);
        cfg_sel  = 3'(wsel);
        for (int i = 0; i < NP; i++) begin
            in_data[i*DW +: DW] = DW'($urandom);
            in_valid[i]         = 1'($urandom);
        end
        for (int o = 0; o < NP; o++) begin
            ev[o] = exp_valid(o);
            ed[o] = exp_data(o);
        end
        @(negedge clk);
        for (int o = 0; o < NP; o++) begin
            check(out_valid[o] == 1'(ev[o]), {req, " valid"}, int'(out_valid[o]), ev[o]);
            check(out_data[o*DW +: DW] == DW'(ed[o]), {req, " data"},
                  int'(out_data[o*DW +: DW]), ed[o]);
        end
        if (we && !en && wp < NP) m_tbl[ws][wp] = wsel;
        if (en) m_slot = (m_slot == NS-1) ? 0 : m_slot + 1;
        else    m_slot = 0;
    endtask

    task automatic run(input int n, input string req);
        for (int k = 0; k < n; k++) cycle(1, 0, 0, 0, 0, req);
    endtask

    task automatic wr(input int s, input int p, input int v, input string req);
        cycle(0, 1, s, p, v, req);
    endtask

    initial begin
        void'($urandom(32'd1234));
        rst = 1'b1; sched_en = 0; cfg_we = 0; cfg_slot = '0; cfg_port = '0; cfg_sel = '0;
        in_data = '0; in_valid = '0;
        m_slot = 0;
        for (int s = 0; s < NS; s++) for (int p = 0; p < NP; p++) m_tbl[s][p] = 7;
        repeat (3) @(negedge clk);
        // R1: reset state at the outputs
        check(out_valid == '0, "R1 reset valid", int'(out_valid), 0);
        check(out_data == '0, "R1 reset data", 0, 0);
        rst = 1'b0;
        // R1: empty table gives no valid output under random traffic
        run(2 * NS, "R1 idle table");

        // R7: slot 0 all outputs take local (loopback+multicast); slot 1 all take north
        cycle(0, 0, 0, 0, 0, "R5 stop");
        for (int p = 0; p < NP; p++) wr(0, p, 4, "R7 cfg");
        for (int p = 0; p < NP; p++) wr(1, p, 0, "R7 cfg");
        // R3: idle codes 5 and 6 in slot 2
        wr(2, 0, 5, "R3 cfg"); wr(2, 1, 6, "R3 cfg"); wr(2, 4, 3, "R3 cfg");
        run(NS + 3, "R7 multicast");

        // R6: writes while running are ignored
        for (int k = 0; k < 6; k++) cycle(1, 1, k % NS, k % NP, 2, "R6 write while run");
        run(NS, "R6 table held");

        // R5: stop mid-schedule and restart from slot 0
        cycle(0, 0, 0, 0, 0, "R5 stop outputs");
        cycle(0, 0, 0, 0, 0, "R5 stop outputs");
        run(3, "R5 restart slot0");
        cycle(0, 0, 0, 0, 0, "R5 stop outputs");

        // R6: writes to a port number above the last are ignored
        wr(0, 5, 1, "R6 bad port"); wr(1, 6, 2, "R6 bad port"); wr(3, 7, 0, "R6 bad port");
        run(NS, "R6 bad port ignored");
        cycle(0, 0, 0, 0, 0, "R5 stop");

        // R2/R3/R4: random tables with every code value, runs past the wrap
        for (int t = 0; t < 6; t++) begin
            for (int s = 0; s < NS; s++)
                for (int p = 0; p < NP; p++) wr(s, p, int'($urandom_range(0, 7)), "R6 cfg");
            run(3 * NS + int'($urandom_range(0, NS)), "R2 R4 random route");
            cycle(0, 0, 0, 0, 0, "R5 stop");
        end

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #1000000;
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule